// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the address stream for a burst-capable synchronous memory. When the control input `adv_i` is low at a rising clock edge, the block captures a complete start address. When it is high, the block steps a two-bit beat counter. It then presents the next address of a four-beat burst. Only the low two address bits move. The bits above them keep the loaded value for the whole burst.

A strap-style input `ilv_i` selects the order of the low bits. With `ilv_i` low they count up from the start value and wrap within four (linear order). With `ilv_i` high they are the start value XOR the beat number (interleaved order). After four accesses the sequence comes back to the loaded address. The memory that consumes the address sits outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: When `adv_i` is 0 at a rising edge, then from that edge on `addr_o` equals the `addr_i` sampled at that edge and `beat_o` is 0.
- R2: When `adv_i` is 1 at a rising edge, `beat_o` becomes the previous `beat_o` plus 1, modulo 4.
- R3: Four advances after a load, `beat_o` is 0 again and `addr_o` equals the loaded address. This is the fifth access of the burst.
- R4: With `ilv_i` = 0, `addr_o[1:0]` equals the loaded bits [1:0] plus `beat_o`, modulo 4. A start of 01 gives 01,10,11,00, and a start of 11 gives 11,00,01,10.
- R5: With `ilv_i` = 1, `addr_o[1:0]` equals the loaded bits [1:0] XOR `beat_o`. A start of 01 gives 01,00,11,10, and a start of 11 gives 11,10,01,00.
- R6: `addr_o` bits above bit 1 keep the loaded value during advances. A wrap of the low bits never carries into them.
- R7: While `rst_ni` is low, and after reset until the first load, `addr_o` and `beat_o` are 0. Advances that come without a prior load step from address 0.
- R8: A load during a burst restarts the sequence at once. The new address appears with `beat_o` 0 on the edge of the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | 0 = load `addr_i`, 1 = advance the burst |
| addr_i | input | ADDR_W | Start address, captured on a load |
| ilv_i | input | 1 | Order select: 0 linear, 1 interleaved (static) |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
Every result is due one edge after its stimulus. The load or advance is sampled at a rising edge, and the new `addr_o` and `beat_o` come from the registers that this edge updates. The order select acts through logic with no register, so a change in it shows on the same cycle. The bench drives inputs on the falling edge and samples outputs on the next falling edge. Each check therefore sees exactly one rising edge between stimulus and sample. The checker's properties use `|=>` for the same one-edge delay.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [BEAT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] cnt;
    } state_t;

    localparam logic [BEAT_W-1:0] CNT_ONE = BEAT_W'(1);

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!adv_i) begin
            st_d.base = addr_i;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.base;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [BEAT_W-1:0] cnt_i,
    input  order_e            order_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] xor_low;
    logic [BEAT_W-1:0] low_d;

    // each low bit of the interleaved address is its own XOR
    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign xor_low[i] = base_i[i] ^ cnt_i[i];
    end

    // the sum is truncated to BEAT_W bits, so the low bits wrap without a carry out
    assign lin_low = base_i[BEAT_W-1:0] + cnt_i;

    always_comb begin
        unique case (order_i)
            ORDER_XOR: low_d = xor_low;
            default:   low_d = lin_low;
        endcase
    end

    assign addr_o = {base_i[ADDR_W-1:BEAT_W], low_d};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ilv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BEAT_W-1:0] beat_o
);

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    order_e            order;

    assign order = ilv_i ? ORDER_XOR : ORDER_LINEAR;

    burst_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (adv_i),
        .addr_i (addr_i),
        .base_o (base_q),
        .cnt_o  (cnt_q)
    );

    burst_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_seq (
        .base_i  (base_q),
        .cnt_i   (cnt_q),
        .order_i (order),
        .addr_o  (addr_o)
    );

    assign beat_o = cnt_q;

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              adv_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ilv_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [BEAT_W-1:0] beat_o
);

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);
    localparam logic [BEAT_W-1:0] TOP = {BEAT_W{1'b1}};

    AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> (addr_o == $past(addr_i)) && (beat_o == '0)); // R1

    AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> beat_o == $past(beat_o) + ONE); // R2

    AST_BEAT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && beat_o == TOP) |=> beat_o == '0); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !ilv_i) |=> (ilv_i || (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + ONE))); // R4

    AST_XOR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && ilv_i) |=> (!ilv_i || ((addr_o[BEAT_W-1:0] ^ beat_o) == $past(addr_o[BEAT_W-1:0] ^ beat_o)))); // R5

    AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R6

    always_comb begin
        if (!rst_ni) begin
            AST_RESET_ZERO: assert ((addr_o == '0) && (beat_o == '0)); // R7
        end
    end

endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv_i),
    .addr_i (addr_i),
    .ilv_i  (ilv_i),
    .addr_o (addr_o),
    .beat_o (beat_o)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ilv = 1'b0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u0 (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .adv_i  (adv),
        .addr_i (addr_in),
        .ilv_i  (ilv),
        .addr_o (addr_out),
        .beat_o (beat)
    );

    function automatic logic [AW-1:0] model(input logic [AW-1:0] s, input logic [1:0] b, input logic il);
        logic [1:0] lo;
        lo = il ? (s[1:0] ^ b) : (s[1:0] + b);
        return {s[AW-1:2], lo};
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] ea, input logic [1:0] eb);
        n_chk++;
        if (addr_out !== ea || beat !== eb) begin
            n_bad++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d", req, addr_out, beat, ea, eb);
        end
    endtask

    // drive at falling edge, one rising edge, sample at the next falling edge
    task automatic step(input logic a, input logic [AW-1:0] ad);
        adv = a;
        addr_in = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R7 reset", '0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 after reset", '0, 2'd0);
        for (int i = 1; i <= 4; i++) begin
            step(1'b1, 20'hABCDE);
            chk("R7 advance from zero", model('0, 2'(i), 1'b0), 2'(i));
        end
    endtask

    task automatic t_burst(input logic [AW-1:0] s, input logic il, input string req);
        ilv = il;
        step(1'b0, s);
        chk("R1 load", s, 2'd0);
        for (int i = 1; i <= 3; i++) begin
            step(1'b1, ~s);
            chk(req, model(s, 2'(i), il), 2'(i));
            chk("R2 beat step", model(s, 2'(i), il), 2'(i));
        end
        step(1'b1, ~s);
        chk("R3 fifth access wraps", s, 2'd0);
    endtask

    task automatic t_upper();
        ilv = 1'b0;
        step(1'b0, 20'h0FFFF);
        step(1'b1, '0);
        chk("R6 no carry into upper bits", 20'h0FFFC, 2'd1);
        step(1'b1, '0);
        step(1'b1, '0);
        chk("R6 upper held", 20'h0FFFE, 2'd3);
    endtask

    task automatic t_restart();
        ilv = 1'b1;
        step(1'b0, 20'h12341);
        step(1'b1, '0);
        step(1'b1, '0);
        chk("R8 before restart", 20'h12343, 2'd2);
        step(1'b0, 20'h55552);
        chk("R8 restart loads at once", 20'h55552, 2'd0);
        step(1'b1, '0);
        chk("R8 continues from new start", 20'h55553, 2'd1);
    endtask

    function automatic void report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endfunction

    initial begin
        @(negedge clk);
        t_reset();
        t_burst(20'h00001, 1'b0, "R4 linear start 01");
        t_burst(20'h3A2B3, 1'b0, "R4 linear start 11");
        t_burst(20'h00001, 1'b1, "R5 interleaved start 01");
        t_burst(20'hC0DE3, 1'b1, "R5 interleaved start 11");
        t_burst(20'h7FF02, 1'b1, "R5 interleaved start 10");
        t_upper();
        t_restart();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            report();
            $finish;
        end
    end

endmodule